// File: doc/BRIEF.md
# Wired-OR Aggregating Shared Memory

This block is a main memory shared by a fixed number of processing elements that run in lockstep. A cycle sequencer outside the block moves every machine cycle through a read phase and then two write phases. In the read phase each processor fetches the cell at its own address, and all processors do this at the same time. In the clear phase every cell that some processor targets with a write is zeroed. In the merge phase each targeted cell takes the bitwise OR of the data from all of its writers. Writes to one cell therefore never conflict and need no priority arbitration. A bit ends up set exactly when at least one writer drives a 1 into it.

Addresses may point past the configured depth. A read there is legal and returns zeros. A write there changes no cell and raises a sticky flag, which reports the lowest-numbered processor that caused it.

Top module: `wor_shared_mem`

## Requirements
- R1: The cell width CELL_W must be a power of two. Any other value stops elaboration.
- R2: The phase input uses this encoding: 0 idle, 1 read, 2 clear, 3 merge. In phase 1, every processor p with its read enable set loads the cell at its address into its `rd_data` slice (bits p*CELL_W upward) one clock later. The value loaded is the cell as it was before this cycle's clear and merge phases. Several processors may read the same cell in the same cycle.
- R3: A read at an address equal to or above DEPTH returns all zeros.
- R4: A processor's `rd_data` slice holds its value in every cycle that is not phase 1, and in any phase-1 cycle where that processor's read enable is low.
- R5: In phase 2, every in-range cell that is the address of a processor with write enable set becomes zero.
- R6: In phase 3, every in-range targeted cell becomes its current value ORed with the data of all processors that write it. After a phase 2 on the same targets, a bit is 1 exactly when at least one writer drives 1 into it.
- R7: A cell that no enabled writer addresses keeps its value through phases 2 and 3.
- R8: In phase 3, a write enable with an address at or above DEPTH changes no cell. The next clock it sets `illegal`.
- R9: `illegal` stays set until reset. `illegal_idx` holds the lowest processor index among the offending writers of the first phase-3 cycle that raised the flag, and later offences do not change it.
- R10: A synchronous active-high reset clears every cell, every `rd_data` slice, `illegal` and `illegal_idx`.
- R11: In phase 0, no cell changes, whatever the write enables and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 2 | Cycle phase: 0 idle, 1 read, 2 clear, 3 merge |
| addr | input | NPROC*ADDR_W | Per-processor cell address, processor p at bits p*ADDR_W |
| wr_data | input | NPROC*CELL_W | Per-processor write data |
| rd_en | input | NPROC | Per-processor read enable |
| wr_en | input | NPROC | Per-processor write enable |
| rd_data | output | NPROC*CELL_W | Registered per-processor read data |
| illegal | output | 1 | Sticky out-of-range write flag |
| illegal_idx | output | max(1,clog2(NPROC)) | Lowest offending processor of the first offence |

## Verification
Four writers target four separate cells, which shows that the address decode keeps processors apart. Then all four write one cell with disjoint single-bit data, and later with overlapping masks, which separates a true OR from last-writer-wins or priority selection. A merge phase without a preceding clear shows that merge adds bits to the existing content rather than replacing it. A read in the same cycle as a later write shows that the read sees the value from before the write. Out-of-range reads and writes use addresses whose low bits alias real cells, so any wrap-around in the decode shows up as corrupted data. The bench also triggers two offending writers at once, followed by a later offence from a lower-numbered processor, to check which index `illegal_idx` keeps.

// File: rtl/wor_pkg.sv
package wor_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_CLEAR = 2'd2,
    PH_MERGE = 2'd3
  } phase_e;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/wor_addr_decode.sv
// Per-processor address decode: a one-hot cell hit matrix for enabled
// writers and an out-of-range indication for every processor.
module wor_addr_decode #(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 16
) (
  input  logic [NPROC*ADDR_W-1:0] addr,
  input  logic [NPROC-1:0]        wr_en,
  output logic [DEPTH*NPROC-1:0]  hit,   // bit c*NPROC+p
  output logic [NPROC-1:0]        oor
);
  localparam int AX_W = ADDR_W + 1;

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    logic [AX_W-1:0] a_ext;
    assign a_ext  = {1'b0, addr[p*ADDR_W +: ADDR_W]};
    assign oor[p] = (a_ext >= AX_W'(DEPTH));
    for (genvar c = 0; c < DEPTH; c++) begin : g_cell
      assign hit[c*NPROC + p] = wr_en[p] && (a_ext == AX_W'(c));
    end
  end

endmodule

// File: rtl/wor_or_reduce.sv
// Per-cell wired-OR of all writer data that hits the cell.
module wor_or_reduce #(
  parameter int NPROC  = 4,
  parameter int CELL_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic [DEPTH*NPROC-1:0]  hit,
  input  logic [NPROC*CELL_W-1:0] wr_data,
  output logic [DEPTH*CELL_W-1:0] merged,
  output logic [DEPTH-1:0]        targeted
);

  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    logic [CELL_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int p = 0; p < NPROC; p++) begin
        if (hit[c*NPROC + p]) acc = acc | wr_data[p*CELL_W +: CELL_W];
      end
    end
    assign merged[c*CELL_W +: CELL_W] = acc;
    assign targeted[c] = |hit[c*NPROC +: NPROC];
  end

endmodule

// File: rtl/wor_cell_array.sv
// Storage cells with the clear and merge write phases.
module wor_cell_array #(
  parameter int CELL_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  wor_pkg::phase_e         phase,
  input  logic [DEPTH-1:0]        targeted,
  input  logic [DEPTH*CELL_W-1:0] merged,
  output logic [DEPTH*CELL_W-1:0] cells
);
  import wor_pkg::*;

  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    logic [CELL_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (targeted[c]) begin
        case (phase)
          PH_CLEAR: q <= '0;
          PH_MERGE: q <= q | merged[c*CELL_W +: CELL_W];
          default:  q <= q;
        endcase
      end
    end
    assign cells[c*CELL_W +: CELL_W] = q;
  end

endmodule

// File: rtl/wor_read_port.sv
// One registered read port per processor; out-of-range selects nothing.
module wor_read_port #(
  parameter int NPROC  = 4,
  parameter int CELL_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  wor_pkg::phase_e         phase,
  input  logic [NPROC*ADDR_W-1:0] addr,
  input  logic [NPROC-1:0]        rd_en,
  input  logic [DEPTH*CELL_W-1:0] cells,
  output logic [NPROC*CELL_W-1:0] rd_data
);
  import wor_pkg::*;
  localparam int AX_W = ADDR_W + 1;

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    logic [CELL_W-1:0] sel;
    logic [CELL_W-1:0] q;
    logic [AX_W-1:0]   a_ext;
    assign a_ext = {1'b0, addr[p*ADDR_W +: ADDR_W]};

    always_comb begin
      sel = '0;
      for (int c = 0; c < DEPTH; c++) begin
        if (a_ext == AX_W'(c)) sel = cells[c*CELL_W +: CELL_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                              q <= '0;
      else if (phase == PH_READ && rd_en[p]) q <= sel;
    end
    assign rd_data[p*CELL_W +: CELL_W] = q;
  end

endmodule

// File: rtl/wor_illegal_track.sv
// Sticky out-of-range write flag with lowest offending processor index.
module wor_illegal_track #(
  parameter int NPROC = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  wor_pkg::phase_e  phase,
  input  logic [NPROC-1:0] wr_en,
  input  logic [NPROC-1:0] oor,
  output logic             illegal,
  output logic [IDX_W-1:0] illegal_idx
);
  import wor_pkg::*;

  logic [NPROC-1:0] bad;
  logic [IDX_W-1:0] first;

  assign bad = wr_en & oor;

  always_comb begin
    first = '0;
    for (int p = NPROC - 1; p >= 0; p--) begin
      if (bad[p]) first = IDX_W'(p);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal     <= 1'b0;
      illegal_idx <= '0;
    end else if (!illegal && phase == PH_MERGE && |bad) begin
      illegal     <= 1'b1;
      illegal_idx <= first;
    end
  end

endmodule

// File: rtl/wor_shared_mem.sv
module wor_shared_mem #(
  parameter int NPROC  = 4,
  parameter int CELL_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 5,
  localparam int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              phase,
  input  logic [NPROC*ADDR_W-1:0] addr,
  input  logic [NPROC*CELL_W-1:0] wr_data,
  input  logic [NPROC-1:0]        rd_en,
  input  logic [NPROC-1:0]        wr_en,
  output logic [NPROC*CELL_W-1:0] rd_data,
  output logic                    illegal,
  output logic [IDX_W-1:0]        illegal_idx
);
  import wor_pkg::*;

  // R1: elaboration-time parameter checks
  if (!is_pow2(CELL_W)) begin : g_bad_width
    $error("CELL_W must be a power of two");
  end
  if (DEPTH < 1 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
    $error("DEPTH must lie in 1 .. 2**ADDR_W");
  end

  phase_e                  ph;
  logic [DEPTH*NPROC-1:0]  hit;
  logic [NPROC-1:0]        oor;
  logic [DEPTH*CELL_W-1:0] merged;
  logic [DEPTH-1:0]        targeted;
  logic [DEPTH*CELL_W-1:0] cells;

  assign ph = phase_e'(phase);

  wor_addr_decode #(.NPROC(NPROC), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
    .addr(addr), .wr_en(wr_en), .hit(hit), .oor(oor)
  );

  wor_or_reduce #(.NPROC(NPROC), .CELL_W(CELL_W), .DEPTH(DEPTH)) u_or (
    .hit(hit), .wr_data(wr_data), .merged(merged), .targeted(targeted)
  );

  wor_cell_array #(.CELL_W(CELL_W), .DEPTH(DEPTH)) u_cells (
    .clk(clk), .rst(rst), .phase(ph), .targeted(targeted),
    .merged(merged), .cells(cells)
  );

  wor_read_port #(.NPROC(NPROC), .CELL_W(CELL_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .phase(ph), .addr(addr), .rd_en(rd_en),
    .cells(cells), .rd_data(rd_data)
  );

  wor_illegal_track #(.NPROC(NPROC), .IDX_W(IDX_W)) u_ill (
    .clk(clk), .rst(rst), .phase(ph), .wr_en(wr_en), .oor(oor),
    .illegal(illegal), .illegal_idx(illegal_idx)
  );

endmodule

// File: rtl/wor_shared_mem_chk.sv
module wor_shared_mem_chk #(
  parameter int NPROC  = 4,
  parameter int CELL_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              phase,
  input logic [NPROC*ADDR_W-1:0] addr,
  input logic [NPROC-1:0]        rd_en,
  input logic [NPROC-1:0]        wr_en,
  input logic [NPROC*CELL_W-1:0] rd_data,
  input logic                    illegal,
  input logic [IDX_W-1:0]        illegal_idx
);
  localparam int AX_W = ADDR_W + 1;

  for (genvar p = 0; p < NPROC; p++) begin : g_p
    logic far;
    assign far = ({1'b0, addr[p*ADDR_W +: ADDR_W]} >= AX_W'(DEPTH));

    p_oor_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd1 && rd_en[p] && far) |=> (rd_data[p*CELL_W +: CELL_W] == '0));

    p_hold_rdata_r4: assert property (@(posedge clk) disable iff (rst)
      !(phase == 2'd1 && rd_en[p]) |=> $stable(rd_data[p*CELL_W +: CELL_W]));

    p_oor_write_flag_r8: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd3 && wr_en[p] && far) |=> illegal);
  end

  p_sticky_flag_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (illegal && $stable(illegal_idx)));

  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (!illegal && illegal_idx == '0 && rd_data == '0));

endmodule

bind wor_shared_mem wor_shared_mem_chk #(
  .NPROC(NPROC), .CELL_W(CELL_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .addr(addr), .rd_en(rd_en),
  .wr_en(wr_en), .rd_data(rd_data), .illegal(illegal), .illegal_idx(illegal_idx)
);

// File: tb/sim_wor_shared_mem.sv
`timescale 1ns/1ps
module sim_wor_shared_mem;
  localparam int NP  = 4;
  localparam int CW  = 8;
  localparam int DEP = 16;
  localparam int AW  = 5;
  localparam int IW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0]    ph;
  logic [AW-1:0] a  [NP];
  logic [CW-1:0] wd [NP];
  logic [NP-1:0] re, we;

  logic [NP*AW-1:0] addr_f;
  logic [NP*CW-1:0] wd_f;
  logic [NP*CW-1:0] rd_f;
  logic             ill;
  logic [IW-1:0]    ill_idx;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      addr_f[p*AW +: AW] = a[p];
      wd_f[p*CW +: CW]   = wd[p];
    end
  end

  wor_shared_mem #(.NPROC(NP), .CELL_W(CW), .DEPTH(DEP), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .phase(ph), .addr(addr_f), .wr_data(wd_f),
    .rd_en(re), .wr_en(we), .rd_data(rd_f), .illegal(ill), .illegal_idx(ill_idx)
  );

  // behavioural reference
  int m_mem [DEP];
  int m_rd  [NP];
  bit m_ill;
  int m_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int nxt [DEP];
    if (rst) begin
      foreach (m_mem[c]) m_mem[c] = 0;
      foreach (m_rd[p]) m_rd[p] = 0;
      m_ill = 0; m_idx = 0;
      return;
    end
    foreach (m_mem[c]) nxt[c] = m_mem[c];
    if (ph == 2'd1)
      for (int p = 0; p < NP; p++)
        if (re[p]) m_rd[p] = (int'(a[p]) < DEP) ? m_mem[a[p]] : 0;
    if (ph == 2'd2)
      for (int p = 0; p < NP; p++)
        if (we[p] && int'(a[p]) < DEP) nxt[a[p]] = 0;
    if (ph == 2'd3) begin
      for (int p = 0; p < NP; p++)
        if (we[p] && int'(a[p]) < DEP) nxt[a[p]] = nxt[a[p]] | int'(wd[p]);
      if (!m_ill)
        for (int p = NP - 1; p >= 0; p--)
          if (we[p] && int'(a[p]) >= DEP) begin m_ill = 1; m_idx = p; end
    end
    foreach (m_mem[c]) m_mem[c] = nxt[c];
  endtask

  // one clock: update model at the edge, compare outputs shortly after
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    for (int p = 0; p < NP; p++)
      check(int'(rd_f[p*CW +: CW]) == m_rd[p], $sformatf("%s rd_data[%0d]", tag, p),
            int'(rd_f[p*CW +: CW]), m_rd[p]);
    check(ill == m_ill, {tag, " illegal"}, int'(ill), int'(m_ill));
    check(int'(ill_idx) == m_idx, {tag, " illegal_idx"}, int'(ill_idx), m_idx);
    @(negedge clk);
  endtask

  task automatic quiet();
    ph = 2'd0; re = '0; we = '0;
    for (int p = 0; p < NP; p++) begin a[p] = '0; wd[p] = '0; end
  endtask

  task automatic rd4(input int a0, input int a1, input int a2, input int a3, input string tag);
    quiet();
    a[0] = AW'(a0); a[1] = AW'(a1); a[2] = AW'(a2); a[3] = AW'(a3);
    re = '1; ph = 2'd1;
    step(tag);
    quiet();
    step(tag);
  endtask

  task automatic wr(input int p, input int ad, input int d);
    we[p] = 1'b1; a[p] = AW'(ad); wd[p] = CW'(d);
  endtask

  task automatic clear_merge(input string tag);
    ph = 2'd2; step(tag);
    ph = 2'd3; step(tag);
    quiet();
  endtask

  initial begin
    quiet();
    @(negedge clk);
    step("R10 reset");
    step("R10 reset");
    rst = 1'b0;
    // R1: width parameter is a power of two
    check((CW > 0) && ((CW & (CW - 1)) == 0), "R1 cell width", CW, CW);
    // R10: every cell reads zero after reset
    for (int b = 0; b < DEP; b += 4) rd4(b, b + 1, b + 2, b + 3, "R10 cell zero");

    // R5/R6: distinct cells per writer
    wr(0, 1, 'hA1); wr(1, 2, 'hB2); wr(2, 3, 'hC3); wr(3, 4, 'hD4);
    clear_merge("R5 R6 distinct");
    rd4(1, 2, 3, 4, "R2 readback distinct");

    // R6: four writers, one cell, disjoint bits
    wr(0, 5, 'h01); wr(1, 5, 'h02); wr(2, 5, 'h04); wr(3, 5, 'h80);
    clear_merge("R6 same cell");
    rd4(5, 5, 5, 5, "R2 R6 same cell 87");

    // R6: overlapping masks
    wr(1, 6, 'h0F); wr(3, 6, 'h3C);
    clear_merge("R6 overlap");
    rd4(6, 6, 0, 0, "R6 overlap 3F");

    // R6: merge without clear accumulates
    wr(0, 5, 'h08); ph = 2'd3; step("R6 accumulate"); quiet();
    rd4(5, 1, 2, 3, "R6 accumulate 8F");

    // R2: read in the same cycle as a later write sees the old value
    a[0] = AW'(1); re[0] = 1'b1; ph = 2'd1; step("R2 read before write");
    quiet(); wr(1, 1, 'h55); clear_merge("R2 write after read");
    rd4(1, 2, 3, 4, "R2 R7 new value and untouched cells");

    // R4: rd_en low in read phase, and rd_en high outside read phase
    quiet(); a[0] = AW'(6); a[1] = AW'(6); a[2] = AW'(6); re = 4'b1011; ph = 2'd1;
    step("R4 rd_en low holds");
    re = '1; ph = 2'd2; step("R4 non-read phase holds");
    ph = 2'd0; step("R4 idle holds");
    quiet();

    // R3: out-of-range reads, aliasing low bits of populated cells
    rd4(16 + 1, 31, 16 + 5, 20, "R3 oor read zero");

    // R11: idle phase with writes enabled
    wr(0, 2, 'hFF); wr(1, 3, 'h00); ph = 2'd0; step("R11 idle write"); quiet();
    rd4(2, 3, 0, 0, "R11 cells unchanged");

    // R5: clear without merge
    wr(2, 3, 'hFF); ph = 2'd2; step("R5 clear only"); quiet();
    rd4(3, 2, 4, 1, "R5 R7 cleared cell");

    // R8/R9: out-of-range writers 2 and 3 together
    wr(2, 16 + 3, 'hFF); wr(3, 16 + 4, 'hFF); ph = 2'd3; step("R8 oor write");
    quiet(); step("R8 R9 flag set idx 2");
    rd4(3, 4, 0, 0, "R8 aliased cells untouched");
    // R9: later offence by lower processor keeps first index
    wr(0, 30, 'h11); ph = 2'd3; step("R9 second offence"); quiet();
    step("R9 sticky idx");
    step("R9 sticky idx");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule